// File: doc/BRIEF.md
# SPI Flash Command Transaction Engine

This block runs one complete serial-flash transaction at a time over a four-wire SPI link in mode 0. A transaction starts with a single command byte. Up to four address bytes follow, and then a payload of outgoing or incoming bytes. The payload length is a 16-bit count and may be zero. Chip select stays asserted low for the whole frame. After the frame, chip select is held high for at least one full SCLK period before the engine will take the next start.

The host sets the command byte, address, address byte count, direction and payload length, and raises `start`. Outgoing payload bytes are pulled from a valid/ready byte stream. When that stream runs dry, SCLK stops in its low phase and waits. Incoming bytes leave on a one-cycle valid strobe. The engine transmits zero bytes while it reads. The SCLK half period is a parameter counted in system clocks. The engine only frames and shifts bytes; it does not interpret commands or status.

Top module: `spi_flash_xact`

## Requirements
- R1: After reset, `cs_n` is 1, `sclk` is 0, and `busy`, `done`, `rx_valid` and `tx_ready` are 0. A `start` seen while idle drives `cs_n` low on the next clock. A `start` raised while `busy` is 1 is ignored and changes neither the current frame nor what follows it.
- R2: The link runs in SPI mode 0. `sclk` is 0 whenever `cs_n` is 1. `mosi` only changes while `sclk` is 0. `miso` is sampled on the clock edge where `sclk` rises.
- R3: Each byte is shifted most-significant bit first, and the command byte is the first byte of every frame.
- R4: `addr_bytes` values 0 to 4 send that many address bytes right after the command byte. Values 5 to 7 are treated as 4. With n address bytes, byte i (counting from 0) is `addr >> 8*(n-1-i)`, so the most significant byte goes first. With n = 0 there is no address phase.
- R5: When `rd_mode` is 1, the engine sends `pay_len` bytes of 0x00. Each received byte appears on `rx_data`, with `rx_valid` high for exactly one clock after that byte's eighth falling SCLK edge.
- R6: When `rd_mode` is 0, the engine sends `pay_len` bytes taken in order from the tx stream, one per `tx_valid && tx_ready` handshake. While no byte is offered, `sclk` stays low and `cs_n` stays low.
- R7: When `pay_len` is 0, the frame ends right after the command and address bytes, and no stream handshake takes place.
- R8: Each transaction has exactly one falling and one rising edge of `cs_n`, with 8*(1+n+`pay_len`) rising `sclk` edges between them. `busy` is 1 whenever `cs_n` is 0.
- R9: `done` is high for exactly one clock, one clock after `cs_n` returns high.
- R10: After a frame, `cs_n` stays high for at least 2*`DIV_HALF` clocks (one SCLK period) before the next frame starts, and `busy` stays 1 until then.
- R11: Every high phase of `sclk` lasts exactly `DIV_HALF` system clocks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (accepted only when idle) |
| opcode | input | 8 | Command byte |
| addr | input | 32 | Address, right-aligned |
| addr_bytes | input | 3 | Number of address bytes (0..4; larger values mean 4) |
| rd_mode | input | 1 | 1: payload is received; 0: payload is sent |
| pay_len | input | LEN_W | Payload byte count |
| busy | output | 1 | Transaction or trailing chip-select gap in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| tx_data | input | 8 | Outgoing payload byte |
| tx_valid | input | 1 | `tx_data` is offered |
| tx_ready | output | 1 | Engine takes `tx_data` this cycle |
| rx_data | output | 8 | Received payload byte |
| rx_valid | output | 1 | `rx_data` is new this cycle |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The embedded assertions check, on every cycle, the properties that never depend on frame contents: SCLK idles low outside chip select, MOSI holds steady while SCLK is high, chip select falls only in answer to an idle start, streaming strobes occur only inside a frame with SCLK low, and the `done` pulse is single and follows chip-select release. The bench checks the rest with scenarios: the exact byte sequence on MOSI for every address count and payload length in a sweep, the data sampled from MISO on rising edges, tx-stream ordering under stalls, clamping of oversized address counts, the inter-frame gap, and the rejection of starts during a frame.

// File: rtl/spi_flash_xact.sv
module spi_flash_xact #(
  parameter int DIV_HALF = 4,
  parameter int LEN_W    = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [7:0]       opcode,
  input  logic [31:0]      addr,
  input  logic [2:0]       addr_bytes,
  input  logic             rd_mode,
  input  logic [LEN_W-1:0] pay_len,
  output logic             busy,
  output logic             done,
  input  logic [7:0]       tx_data,
  input  logic             tx_valid,
  output logic             tx_ready,
  output logic [7:0]       rx_data,
  output logic             rx_valid,
  output logic             sclk,
  output logic             cs_n,
  output logic             mosi,
  input  logic             miso
);

  localparam int CW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;

  typedef enum logic [2:0] {S_IDLE, S_SHIFT, S_LOAD, S_HOLD, S_GAP} st_t;

  st_t              st;
  logic [CW-1:0]    cnt;
  logic             ph;
  logic [2:0]       bitn;
  logic [7:0]       sr, rxsr;
  logic [31:0]      asr;
  logic [2:0]       aleft;
  logic [LEN_W-1:0] dleft;
  logic             rd_q, cur_data, cs_q;

  wire       tick  = (cnt == CW'(DIV_HALF - 1));
  wire       timed = (st == S_SHIFT) || (st == S_HOLD) || (st == S_GAP);
  wire [2:0] nab   = (addr_bytes > 3'd4) ? 3'd4 : addr_bytes;

  assign busy     = (st != S_IDLE);
  assign mosi     = sr[7] & ~cs_n;
  assign tx_ready = (st == S_LOAD) && (aleft == 3'd0) && (dleft != '0) && !rd_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (timed && !tick) cnt <= cnt + 1'b1;
    else cnt <= '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= S_IDLE;
      ph       <= 1'b0;
      bitn     <= 3'd0;
      sr       <= 8'h00;
      rxsr     <= 8'h00;
      asr      <= 32'h0;
      aleft    <= 3'd0;
      dleft    <= '0;
      rd_q     <= 1'b0;
      cur_data <= 1'b0;
      sclk     <= 1'b0;
      cs_n     <= 1'b1;
      rx_data  <= 8'h00;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          cs_n     <= 1'b0;
          sr       <= opcode;
          asr      <= addr << {3'd4 - nab, 3'b000};
          aleft    <= nab;
          dleft    <= pay_len;
          rd_q     <= rd_mode;
          cur_data <= 1'b0;
          bitn     <= 3'd0;
          ph       <= 1'b0;
          st       <= S_SHIFT;
        end
        S_SHIFT: if (tick) begin
          if (!ph) begin
            sclk <= 1'b1;
            rxsr <= {rxsr[6:0], miso};
            ph   <= 1'b1;
          end else begin
            sclk <= 1'b0;
            ph   <= 1'b0;
            sr   <= {sr[6:0], 1'b0};
            bitn <= bitn + 3'd1;
            if (bitn == 3'd7) begin
              st <= S_LOAD;
              if (cur_data && rd_q) begin
                rx_data  <= rxsr;
                rx_valid <= 1'b1;
              end
            end
          end
        end
        S_LOAD: begin
          if (aleft != 3'd0) begin
            sr       <= asr[31:24];
            asr      <= {asr[23:0], 8'h00};
            aleft    <= aleft - 3'd1;
            cur_data <= 1'b0;
            st       <= S_SHIFT;
          end else if (dleft != '0) begin
            if (rd_q) begin
              sr       <= 8'h00;
              dleft    <= dleft - 1'b1;
              cur_data <= 1'b1;
              st       <= S_SHIFT;
            end else if (tx_valid) begin
              sr       <= tx_data;
              dleft    <= dleft - 1'b1;
              cur_data <= 1'b1;
              st       <= S_SHIFT;
            end
          end else begin
            st <= S_HOLD;
          end
        end
        S_HOLD: if (tick) begin
          cs_n <= 1'b1;
          ph   <= 1'b0;
          st   <= S_GAP;
        end
        S_GAP: if (tick) begin
          ph <= ~ph;
          if (ph) st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_q <= 1'b1;
      done <= 1'b0;
    end else begin
      cs_q <= cs_n;
      done <= cs_n && !cs_q;
    end
  end

  AST_SCLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> !sclk); // R2
  AST_MOSI_HELD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> $stable(mosi)); // R2
  AST_CS_FROM_IDLE_START: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cs_n) |-> ($past(start) && !$past(busy))); // R1
  AST_BUSY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_n |-> busy); // R8
  AST_RX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (!cs_n && !sclk)); // R5
  AST_TX_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> (!cs_n && !sclk)); // R6
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R9
  AST_DONE_AFTER_CS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cs_n && $past(cs_n))); // R9
  AST_GAP_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> busy); // R10

endmodule

// File: tb/spi_flash_xact_test.sv
`timescale 1ns/1ps
module spi_flash_xact_test;
  localparam int DH = 2;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic        rst_n, start, rd_mode, miso, tx_valid;
  logic [7:0]  opcode, tx_data;
  logic [31:0] addr;
  logic [2:0]  addr_bytes;
  logic [15:0] pay_len;
  logic        busy, done, tx_ready, rx_valid, sclk, cs_n, mosi;
  logic [7:0]  rx_data;

  spi_flash_xact #(.DIV_HALF(DH), .LEN_W(16)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .opcode(opcode), .addr(addr),
    .addr_bytes(addr_bytes), .rd_mode(rd_mode), .pay_len(pay_len),
    .busy(busy), .done(done), .tx_data(tx_data), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .rx_data(rx_data), .rx_valid(rx_valid),
    .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso));

  function automatic logic [7:0] txpat(input int i);
    return 8'(i * 29 + 7);
  endfunction
  function automatic logic [7:0] mpat(input int b);
    return 8'((b * 53 + 11) ^ 8'h96);
  endfunction

  int checks = 0, fails = 0;
  int cyc = 0, tx_idx = 0;
  logic stall = 1'b0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tx_valid && tx_ready) tx_idx <= tx_idx + 1;
  end
  assign tx_data  = txpat(tx_idx);
  assign tx_valid = !(stall && ((cyc % 11) < 6));

  int sbits = 0;
  logic [7:0] mb;
  always_comb mb = mpat(sbits / 8);
  assign miso = mb[7 - (sbits % 8)];

  logic [7:0] mo [0:31];
  logic [7:0] rxb [0:31];
  logic [7:0] cur = 8'h00;
  logic prev_cs = 1'b1, prev_sclk = 1'b0, done_next = 1'b0;
  int nbits = 0, nby = 0, nrx = 0, nfall = 0, hi_len = 0, hi_bad = 0;
  int gap_cnt = 0, last_gap = 0, done_bad = 0, stray_done = 0;
  logic frame_done = 1'b0, busy_at_done = 1'b0;

  always @(negedge clk) begin
    if (prev_cs && !cs_n) begin
      nbits = 0; nby = 0; nrx = 0; sbits = 0; hi_bad = 0;
      nfall = nfall + 1; last_gap = gap_cnt; gap_cnt = 0;
    end
    if (cs_n) gap_cnt = gap_cnt + 1;
    if (!cs_n && sclk && !prev_sclk) begin
      cur = {cur[6:0], mosi};
      nbits = nbits + 1;
      sbits = sbits + 1;
      if (nbits % 8 == 0) begin
        if (nby < 32) mo[nby] = cur;
        nby = nby + 1;
      end
      hi_len = 1;
    end else if (sclk && prev_sclk) hi_len = hi_len + 1;
    if (!sclk && prev_sclk && hi_len != DH) hi_bad = hi_bad + 1;
    if (rx_valid) begin
      if (nrx < 32) rxb[nrx] = rx_data;
      nrx = nrx + 1;
    end
    if (cs_n && !prev_cs) begin
      if (done) done_bad = done_bad + 1;
      done_next = 1'b1;
    end else if (done_next) begin
      if (!done) done_bad = done_bad + 1;
      busy_at_done = busy;
      done_next = 1'b0;
      frame_done = 1'b1;
    end else if (done) stray_done = stray_done + 1;
    prev_cs = cs_n;
    prev_sclk = sclk;
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) if (cyc == 190000) begin
    fails++;
    $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  int nframes = 0;

  task automatic run(input logic [7:0] op, input logic [31:0] ad, input int nab,
                     input bit rd, input int len, input bit stl, input bit poke);
    int n, base, ex;
    n = (nab > 4) ? 4 : nab;
    @(negedge clk);
    stall = stl;
    base = tx_idx;
    frame_done = 1'b0;
    nfall = 0;
    opcode = op; addr = ad; addr_bytes = 3'(nab); rd_mode = rd;
    pay_len = 16'(len); start = 1'b1;
    do @(negedge clk); while (cs_n);
    start = 1'b0;
    if (nframes > 0)
      chk(last_gap >= 2 * DH, "R10", "chip-select gap cycles", last_gap, 2 * DH);
    if (poke) begin
      repeat (20) @(negedge clk);
      opcode = ~op; start = 1'b1;
      @(negedge clk);
      start = 1'b0; opcode = op;
    end
    while (!frame_done) @(posedge clk);
    @(posedge clk);
    ex = 1 + n + len;
    chk(nby == ex, "R8", "byte count", nby, ex);
    chk(nby == ex && mo[0] == op, "R3", "command byte", mo[0], op);
    for (int i = 0; i < n && i + 1 < 32; i++)
      chk(mo[1 + i] == 8'(ad >> (8 * (n - 1 - i))), "R4", "address byte",
          mo[1 + i], 8'(ad >> (8 * (n - 1 - i))));
    for (int i = 0; i < len && 1 + n + i < 32; i++) begin
      if (rd) chk(mo[1 + n + i] == 8'h00, "R5", "read filler byte", mo[1 + n + i], 0);
      else chk(mo[1 + n + i] == txpat(base + i), "R6", "written byte",
               mo[1 + n + i], txpat(base + i));
    end
    chk(nrx == (rd ? len : 0), "R5", "received byte count", nrx, rd ? len : 0);
    for (int i = 0; i < nrx && i < 32 && rd; i++)
      chk(rxb[i] == mpat(1 + n + i), "R5", "received byte", rxb[i], mpat(1 + n + i));
    chk(tx_idx - base == (rd ? 0 : len), (len == 0) ? "R7" : "R6",
        "stream handshakes", tx_idx - base, rd ? 0 : len);
    chk(hi_bad == 0, "R11", "bad sclk high phases", hi_bad, 0);
    chk(nfall == 1, "R8", "chip-select falls", nfall, 1);
    chk(done_bad == 0 && stray_done == 0, "R9", "done timing errors",
        done_bad + stray_done, 0);
    chk(busy_at_done, "R10", "busy during gap", busy_at_done, 1);
    if (poke) begin
      repeat (12) @(negedge clk);
      chk(cs_n && nfall == 1, "R1", "frames after ignored start", nfall, 1);
    end
    nframes++;
  endtask

  initial begin
    rst_n = 1'b0; start = 1'b0; opcode = 8'h00; addr = 32'h0;
    addr_bytes = 3'd0; rd_mode = 1'b0; pay_len = 16'd0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cs_n == 1'b1, "R1", "reset cs_n", cs_n, 1);
    chk(sclk == 1'b0, "R2", "reset sclk", sclk, 0);
    chk({busy, done, rx_valid, tx_ready} == 4'b0, "R1", "reset strobes",
        {busy, done, rx_valid, tx_ready}, 0);

    for (int nab = 0; nab <= 5; nab++)
      for (int rd = 0; rd < 2; rd++)
        for (int len = 0; len < 4; len++)
          run(8'(8'h3C + nab * 16 + rd * 8 + len), 32'hA1B2C3D4 + 32'(nab * 257),
              nab, rd[0], len, 1'b0, 1'b0);

    run(8'h02, 32'h00123456, 3, 1'b0, 17, 1'b1, 1'b0);
    run(8'h03, 32'h00FEDCBA, 3, 1'b1, 17, 1'b0, 1'b1);
    run(8'hC7, 32'h0, 0, 1'b0, 0, 1'b1, 1'b1);
    run(8'h13, 32'h89ABCDEF, 7, 1'b0, 5, 1'b1, 1'b0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule